// File: doc/BRIEF.md
# Byte-Addressed I2C GPIO Expander

This block is a serial-bus slave that gives a host eight general-purpose pins, each usable as an input or an output. The host reaches four byte-wide registers through a pointer that it sets with a command byte. The registers are a pin-sample register, an output latch, a read-inversion mask and a direction mask. The block recovers bus events from oversampled SCL and SDA lines and compares the address byte against a 7-bit address from an external strap decoder. It acknowledges its own bytes by pulling SDA low through an open-drain enable.

An active-low open-drain interrupt line reports that an input pin has moved away from the value last captured in the pin-sample register. Reading the pin-sample register recaptures the pins, which clears the interrupt. Pins set as outputs never raise it.

A typical access is a write of the command byte followed by data bytes. Reads use a write of the command byte, then a repeated START and an address byte with the read bit set.

Top module: `gpx_expander`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal `dev_addr`. For any other address it leaves SDA released and changes no register for the rest of that transaction.
- R2: Only bits 1:0 of the command byte set the pointer: 0 is the pin-sample register, 1 the output latch, 2 the inversion mask and 3 the direction mask. Bits 7:2 are ignored.
- R3: After reset the output latch is 0xFF, the inversion mask is 0x00 and the direction mask is 0xFF, so every pin is an input and the interrupt is released.
- R4: `pin_oe[i]` is high exactly when direction bit i is 0, meaning output. `pin_o` always shows the output latch.
- R5: A read with pointer 0 returns the synchronised pin levels XOR the inversion mask. The pins are sampled at the SCL falling edge that ends the acknowledge before that byte.
- R6: Reads with pointer 1, 2 or 3 return the stored register byte without inversion.
- R7: A byte written to the output latch is on `pin_o` during the acknowledge bit of that data byte.
- R8: A data byte written while the pointer is 0 changes no register.
- R9: The pointer holds across consecutive data bytes. Several written bytes all land in the same register, and several read bytes all come from the same register.
- R10: `irq_oe` is high when any pin with direction bit 1 differs from its bit in the pin-sample register. A pin with direction bit 0 never raises it.
- R11: A read with pointer 0 loads the pin-sample register, which clears `irq_oe` if the pins then stay still.
- R12: The block changes `sda_oe` only while SCL is low. It acknowledges address, command and data bytes. After the host NACKs a read byte it keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls SDA low |
| dev_addr | input | 7 | Slave address from strap decoder |
| pin_i | input | 8 | Pin levels as seen at the pads |
| pin_o | output | 8 | Output latch value for the pads |
| pin_oe | output | 8 | Per-pin output driver enable |
| irq_oe | output | 1 | High pulls the interrupt line low |

## Verification
The bench writes a direction mask and then toggles pins on both sides of it. A design that compared output pins as well as input pins would raise the interrupt when only the output latch changed. It also writes to the pin-sample register a byte that would clear a pending interrupt if it were taken; a design that did not ignore that write would drop the interrupt. A command byte with junk in its upper bits catches a decoder that uses more than two bits. Multi-byte writes and reads catch a pointer that advances. The bench also checks `pin_o` in the middle of the acknowledge bit and checks SDA after a host NACK. These catch late output updates and a slave that keeps driving data into a STOP.

// File: rtl/gpx_pkg.sv
// Shared types for the GPIO expander: register pointer codes and
// the byte-level slave states. Assumes a fixed 8-bit register width.
package gpx_pkg;
    localparam int GPX_BYTE = 8;

    typedef enum logic [1:0] {
        PTR_SAMPLE = 2'd0,
        PTR_LATCH  = 2'd1,
        PTR_INVERT = 2'd2,
        PTR_DIR    = 2'd3
    } gpx_ptr_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } gpx_state_e;
endpackage

// File: rtl/gpx_sync_vec.sv
// Multi-stage synchroniser for a vector of asynchronous levels.
// Assumes STAGES >= 2; the reset value is loaded into every stage.
module gpx_sync_vec #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: W];

    initial begin
        a_r12_sync_depth: assert (STAGES >= 2)
            else $error("synchroniser needs at least two stages");
    end
endmodule

// File: rtl/gpx_i2c_slave.sv
// Byte-level serial-bus slave. Takes synchronised SCL/SDA, finds
// START/STOP and edges, matches the 7-bit address, acknowledges bytes
// and shifts read data out. Assumes clk oversamples SCL by several
// cycles per phase. The command byte is always the first written byte.
module gpx_i2c_slave
    import gpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic [6:0]          dev_addr,
    input  logic [GPX_BYTE-1:0] rd_data,
    output logic                sda_oe,
    output logic                cmd_stb,
    output logic                wr_stb,
    output logic                rd_cap,
    output logic [GPX_BYTE-1:0] rx_byte
);
    localparam logic [3:0] FULL = 4'(GPX_BYTE);

    gpx_state_e          state;
    logic [3:0]          bit_cnt;
    logic [GPX_BYTE-1:0] shreg;
    logic                scl_d, sda_d;
    logic                rnw_q;
    logic                host_nack;
    logic                scl_rise, scl_fall, start_det, stop_det;

    // Remember last bus levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    // Capture strobe: the SCL fall closing an ack before a read byte.
    assign rd_cap = scl_fall &
                    (((state == ST_ADDR_ACK) & rnw_q) |
                     ((state == ST_RDATA_ACK) & ~host_nack));
    assign rx_byte = shreg;

    // Main slave sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            sda_oe    <= 1'b0;
            rnw_q     <= 1'b0;
            host_nack <= 1'b0;
            cmd_stb   <= 1'b0;
            wr_stb    <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            wr_stb  <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[GPX_BYTE-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == dev_addr) begin
                                    sda_oe <= 1'b1;
                                    rnw_q  <= shreg[0];
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_CMD) begin
                                cmd_stb <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_CMD_ACK;
                            end else begin
                                wr_stb <= 1'b1;
                                sda_oe <= 1'b1;
                                state  <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rnw_q) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[GPX_BYTE-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == FULL - 4'd1) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RDATA_ACK;
                            end else begin
                                shreg  <= {shreg[GPX_BYTE-2:0], 1'b0};
                                sda_oe <= ~shreg[GPX_BYTE-2];
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise) begin
                            host_nack <= sda_s;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (!host_nack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[GPX_BYTE-1];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12: SDA drive only changes while SCL is low.
    a_r12_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    a_r12_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);
    // R1: a foreign address leaves the bus released.
    a_r1_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && !start_det && !stop_det &&
         bit_cnt == FULL && shreg[7:1] != dev_addr)
        |=> (state == ST_IDLE && !sda_oe));
    // R12: the SCL fall after a host NACK leaves SDA released.
    a_r12_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK && host_nack && scl_fall && !start_det)
        |=> !sda_oe);
endmodule

// File: rtl/gpx_regs.sv
// Register file of the expander: pointer, output latch, inversion
// mask, direction mask, pin-sample register and interrupt. Assumes the
// pin inputs arrive already synchronised. The pin-sample register
// resets to all ones, matching pulled-up idle pins.
module gpx_regs
    import gpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GPX_BYTE-1:0] pin_s,
    input  logic                cmd_stb,
    input  logic                wr_stb,
    input  logic                rd_cap,
    input  logic [GPX_BYTE-1:0] rx_byte,
    output logic [GPX_BYTE-1:0] rd_data,
    output logic [GPX_BYTE-1:0] pin_o,
    output logic [GPX_BYTE-1:0] pin_oe,
    output logic                irq
);
    gpx_ptr_e            ptr_q;
    logic [GPX_BYTE-1:0] latch_q, inv_q, dir_q, sample_q;
    logic [GPX_BYTE-1:0] moved;
    logic                irq_q;

    // Pointer and writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= PTR_SAMPLE;
            latch_q <= '1;
            inv_q   <= '0;
            dir_q   <= '1;
        end else begin
            if (cmd_stb) ptr_q <= gpx_ptr_e'(rx_byte[1:0]);
            if (wr_stb) begin
                case (ptr_q)
                    PTR_LATCH:  latch_q <= rx_byte;
                    PTR_INVERT: inv_q   <= rx_byte;
                    PTR_DIR:    dir_q   <= rx_byte;
                    default:    ;
                endcase
            end
        end
    end

    // Pin-sample register loads only on a read with pointer 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sample_q <= '1;
        else if (rd_cap && ptr_q == PTR_SAMPLE)  sample_q <= pin_s;
    end

    // Per-pin change detect, masked to pins set as inputs.
    for (genvar i = 0; i < GPX_BYTE; i++) begin : g_moved
        assign moved[i] = dir_q[i] & (pin_s[i] ^ sample_q[i]);
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |moved;
    end

    // Read multiplexer.
    always_comb begin
        case (ptr_q)
            PTR_SAMPLE: rd_data = pin_s ^ inv_q;
            PTR_LATCH:  rd_data = latch_q;
            PTR_INVERT: rd_data = inv_q;
            default:    rd_data = dir_q;
        endcase
    end

    assign pin_o  = latch_q;
    assign pin_oe = ~dir_q;
    assign irq    = irq_q;

    // R4: the direction mask moves only on a write with pointer 3.
    a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && ptr_q == PTR_DIR) |=> $stable(dir_q));
    // R8: the sample register moves only on a pointer-0 read capture.
    a_r8_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_cap && ptr_q == PTR_SAMPLE) |=> $stable(sample_q));
    // R10: with every pin an output no interrupt follows.
    a_r10_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == '0) |=> !irq_q);
    // R11: a capture with still pins clears the interrupt.
    a_r11_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && ptr_q == PTR_SAMPLE) ##1 $stable(pin_s) |=> !irq_q);
endmodule

// File: rtl/gpx_expander.sv
// Top of the I2C GPIO expander: bus and pin synchronisers, byte-level
// slave and register file. Assumes clk runs much faster than SCL and
// that open-drain pads outside turn sda_oe / irq_oe into pull-downs.
module gpx_expander #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [6:0] dev_addr,
    input  logic [7:0] pin_i,
    output logic [7:0] pin_o,
    output logic [7:0] pin_oe,
    output logic       irq_oe
);
    import gpx_pkg::*;

    logic [1:0]          bus_s;
    logic [GPX_BYTE-1:0] pin_s, rd_data, rx_byte;
    logic                cmd_stb, wr_stb, rd_cap;

    gpx_sync_vec #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

    gpx_sync_vec #(.W(GPX_BYTE), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s));

    gpx_i2c_slave i_slave (
        .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe),
        .cmd_stb(cmd_stb), .wr_stb(wr_stb), .rd_cap(rd_cap), .rx_byte(rx_byte));

    gpx_regs i_regs (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .cmd_stb(cmd_stb),
        .wr_stb(wr_stb), .rd_cap(rd_cap), .rx_byte(rx_byte),
        .rd_data(rd_data), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq_oe));
endmodule

// File: tb/test_gpx_expander.sv
// Scoreboard bench: read tasks push expected bytes, a monitor pops
// them as the slave returns read data.
module test_gpx_expander;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] DEV = 7'h27;

    typedef struct { logic [7:0] d; string tag; } exp_t;

    logic       clk = 0, rst_n = 0;
    logic       scl_m = 1, sda_m = 1;
    logic [7:0] pin_drv = 8'hFF;
    logic       sda_oe, irq_oe;
    logic [7:0] pin_o, pin_oe, pin_line, pin_at_ack, rd_val;
    wire        sda_line = sda_m & ~sda_oe;
    int         vecs = 0, fails = 0;
    bit         done = 0;
    exp_t       sb[$];
    event       rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pad
        assign pin_line[i] = pin_oe[i] ? pin_o[i] : pin_drv[i];
    end

    gpx_expander i_gpx_expander (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_addr(DEV), .pin_i(pin_line),
        .pin_o(pin_o), .pin_oe(pin_oe), .irq_oe(irq_oe));

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wq(int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wq();
        sda_m = 0; wq();
        scl_m = 0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1; wq();
        scl_m = 1; wq();
        sda_m = 0; wq();
        scl_m = 0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 0; wq();
        scl_m = 1; wq();
        sda_m = 1; wq(2);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1; wq(2);
            scl_m = 0; wq();
        end
        sda_m = 1; wq();
        pin_at_ack = pin_o;
        scl_m = 1; wq();
        nack = sda_line; wq();
        scl_m = 0; wq();
    endtask

    task automatic rbyte(input logic host_nack, output logic [7:0] d);
        sda_m = 1;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_m = 1; wq();
            d = {d[6:0], sda_line}; wq();
            scl_m = 0; wq();
        end
        sda_m = host_nack; wq();
        scl_m = 1; wq(2);
        scl_m = 0; wq();
        sda_m = 1;
    endtask

    task automatic wr_reg(logic [7:0] cmd, logic [7:0] d0, logic [7:0] d1, int nb);
        logic nk;
        bus_start();
        wbyte({DEV, 1'b0}, nk); chk("R12 addr ack", {7'd0, nk}, 8'd0);
        wbyte(cmd, nk);         chk("R12 cmd ack", {7'd0, nk}, 8'd0);
        wbyte(d0, nk);          chk("R12 data ack", {7'd0, nk}, 8'd0);
        if (nb > 1) wbyte(d1, nk);
        bus_stop();
    endtask

    task automatic rd_reg(logic [7:0] cmd, int nb, logic [7:0] exp, string tag);
        logic nk;
        logic [7:0] d;
        bus_start();
        wbyte({DEV, 1'b0}, nk);
        wbyte(cmd, nk);
        bus_rstart();
        wbyte({DEV, 1'b1}, nk);
        for (int k = 0; k < nb; k++) begin
            sb.push_back('{d: exp, tag: tag});
            rbyte(k == nb - 1, d);
            rd_val = d;
            ->rd_ev;
        end
        wq();
        chk("R12 released after NACK", {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    // Monitor: pop the expected byte for each read result.
    initial begin
        forever begin
            @(rd_ev);
            if (sb.size() == 0) begin
                chk("scoreboard underflow", 8'h01, 8'h00);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, rd_val, e.d);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vecs++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic nk;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R3 reset state
        chk("R3 pin_oe at reset", pin_oe, 8'h00);
        chk("R3 irq at reset", {7'd0, irq_oe}, 8'd0);
        rd_reg(8'h01, 1, 8'hFF, "R3 latch default");
        rd_reg(8'h02, 1, 8'h00, "R3 inversion default");
        rd_reg(8'h03, 1, 8'hFF, "R3 direction default");

        // R1 foreign address: no ack, no effect
        bus_start();
        wbyte({7'h26, 1'b0}, nk);
        chk("R1 foreign addr nack", {7'd0, nk}, 8'd1);
        wbyte(8'h03, nk);
        wbyte(8'h00, nk);
        bus_stop();
        rd_reg(8'h03, 1, 8'hFF, "R1 direction untouched");
        chk("R1 pin_oe untouched", pin_oe, 8'h00);

        // R2 upper command bits ignored, R6 readback
        wr_reg(8'hFE, 8'h0F, 8'h00, 1);
        rd_reg(8'h02, 1, 8'h0F, "R2 R6 inversion readback");

        // R10 input pin change raises irq; R5 inverted read; R11 clear
        pin_drv = 8'h3C;
        repeat (10) @(negedge clk);
        chk("R10 irq on input change", {7'd0, irq_oe}, 8'd1);
        rd_reg(8'h00, 1, 8'h33, "R5 sample read inverted");
        repeat (10) @(negedge clk);
        chk("R11 irq cleared by read", {7'd0, irq_oe}, 8'd0);

        // R4 direction, R7 latch visible at data ack
        wr_reg(8'h03, 8'h0F, 8'h00, 1);
        chk("R4 pin_oe follows direction", pin_oe, 8'hF0);
        wr_reg(8'h01, 8'hA5, 8'h00, 1);
        chk("R7 latch on pins at ack", pin_at_ack, 8'hA5);
        chk("R4 pin_o shows latch", pin_o, 8'hA5);
        repeat (10) @(negedge clk);
        chk("R10 output pins quiet", {7'd0, irq_oe}, 8'd0);
        rd_reg(8'h00, 1, 8'hA3, "R5 mixed pins read");

        // R10 output toggle quiet, input toggle raises
        wr_reg(8'h01, 8'h5A, 8'h00, 1);
        repeat (10) @(negedge clk);
        chk("R10 latch change no irq", {7'd0, irq_oe}, 8'd0);
        pin_drv = 8'h33;
        repeat (10) @(negedge clk);
        chk("R10 irq on input bit", {7'd0, irq_oe}, 8'd1);
        // R8 write with pointer 0 ignored (would clear irq if taken)
        wr_reg(8'h00, 8'h53, 8'h00, 1);
        repeat (10) @(negedge clk);
        chk("R8 pointer-0 write ignored", {7'd0, irq_oe}, 8'd1);
        rd_reg(8'h00, 1, 8'h5C, "R5 R11 sample after change");
        repeat (10) @(negedge clk);
        chk("R11 irq cleared", {7'd0, irq_oe}, 8'd0);

        // R9 pointer fixed across bytes
        wr_reg(8'h01, 8'h11, 8'hC3, 2);
        chk("R9 last written byte on pins", pin_o, 8'hC3);
        rd_reg(8'h01, 2, 8'hC3, "R9 repeated read same register");
        rd_reg(8'h02, 1, 8'h0F, "R9 inversion not hit");

        // R4 back to all inputs
        wr_reg(8'h03, 8'hFF, 8'h00, 1);
        chk("R4 all inputs again", pin_oe, 8'h00);

        done = 1;
        finish_run();
    end
endmodule